// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the refresh duty of an asynchronous-strobe DRAM with 4096 rows that must all be refreshed within 64 ms. After reset it keeps the memory untouched for a power-up pause. It then runs a burst of dummy refresh cycles on its own and only afterwards raises its init-done flag, which releases normal traffic in the main controller. From then on an interval timer adds one unit of refresh debt about every 15.6 µs. The sequencer raises a request toward the main controller while any debt is outstanding.

When the controller answers with a grant, the sequencer takes the row and column strobes and runs one refresh cycle, which pays off one unit of debt. By default each cycle is column-strobe-first: the column strobe falls ahead of the row strobe, so the memory uses its internal row counter. With the mode input high, a cycle instead drives a row address from a local counter and pulses only the row strobe. Debt builds up while the controller is slow to grant, but never beyond a fixed ceiling. The write enable stays high throughout, so that no refresh is taken for a test-mode entry.

Top module: `dref_refresh_seq`

## Requirements
- R1: While reset is held and just after it, req_o, busy_o and init_done_o are 0, and ras_n_o, cas_n_o and we_n_o are 1.
- R2: After reset is released, both strobes stay high for PAUSE_CYC cycles. The first strobe activity appears at most two cycles after that.
- R3: Exactly INIT_CYCLES refresh cycles run after the pause without any grant. init_done_o rises when the last of them ends and stays high until reset.
- R4: Once init_done_o is high, one unit of debt is added every INTERVAL_CYC cycles. req_o is 1 exactly while the debt is nonzero, and it is never 1 before init_done_o.
- R5: Debt saturates at DEBT_MAX. However long grants are withheld, a continuous grant afterwards serves exactly DEBT_MAX cycles before req_o falls, provided no further interval elapses.
- R6: A grant_i received while req_o is 0 starts no cycle: the strobes stay high and busy_o stays 0.
- R7: With ras_only_i = 0 at the start of a cycle, cas_n_o falls T_CSR cycles before ras_n_o falls and stays low for T_CHR cycles from the fall of ras_n_o. ras_n_o is low for T_RAS cycles and then high for at least T_RP cycles before its next fall.
- R8: With ras_only_i = 1 at the start of a cycle, cas_n_o stays high for the whole cycle. ras_n_o is low for T_RAS cycles, and addr_o stays constant while ras_n_o is low.
- R9: The row counter on addr_o is 0 after reset and advances by one after each RAS-only cycle, wrapping modulo 2^ROW_BITS. Column-first cycles leave it unchanged.
- R10: we_n_o is 1 during every refresh cycle.
- R11: busy_o is 1 whenever either strobe is low, and it is 0 again once a cycle's precharge has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Controller hands the strobes to the sequencer |
| ras_only_i | input | 1 | 1 selects RAS-only refresh with an external row address, 0 selects column-first refresh |
| req_o | output | 1 | Refresh debt outstanding |
| busy_o | output | 1 | A refresh cycle is in progress |
| init_done_o | output | 1 | Power-up sequence complete, traffic may start |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| addr_o | output | ROW_BITS | Refresh row address |

## Verification
The assertions take for granted that reset is released only once, and that the pause is at least as long as the precharge time. This keeps the first fall of the row strobe from being judged against an unfinished precharge count. The stimulus never toggles the refresh mode while a cycle is running. It changes the mode only when busy_o is low and the debt is zero. The long no-grant wait is timed from an observed rise of req_o, which places the saturated service burst well clear of the next interval tick.

// File: rtl/dref_pkg.sv
package dref_pkg;
    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_CSR, PH_HOLD, PH_ACT, PH_PRE
    } phase_e;

    typedef enum logic [1:0] {
        ST_PAUSE, ST_INIT, ST_RUN
    } seq_e;
endpackage

// File: rtl/dref_strobe_engine.sv
module dref_strobe_engine
    import dref_pkg::*;
#(
    parameter int T_CSR = 3,
    parameter int T_CHR = 3,
    parameter int T_RAS = 13,
    parameter int T_RP  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ras_only_i,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic busy_o,
    output logic done_o,
    output logic ras_only_o
);
    localparam int M1   = (T_CSR > T_CHR) ? T_CSR : T_CHR;
    localparam int M2   = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int LMAX = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(LMAX + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
        logic          ror;
    } eng_s;

    eng_s eng_d, eng_q;
    logic last;

    always_comb begin
        eng_d = eng_q;
        last  = (eng_q.cnt == '0);
        if (eng_q.ph != PH_IDLE && !last) begin
            eng_d.cnt = eng_q.cnt - CW'(1);
        end else begin
            case (eng_q.ph)
                PH_IDLE: if (start_i) begin
                    eng_d.ror = ras_only_i;
                    if (ras_only_i) begin
                        eng_d.ph  = PH_ADDR;
                        eng_d.cnt = '0;
                    end else begin
                        eng_d.ph  = PH_CSR;
                        eng_d.cnt = CW'(T_CSR - 1);
                    end
                end
                PH_ADDR: begin
                    eng_d.ph  = PH_ACT;
                    eng_d.cnt = CW'(T_RAS - 1);
                end
                PH_CSR: begin
                    eng_d.ph  = PH_HOLD;
                    eng_d.cnt = CW'(T_CHR - 1);
                end
                PH_HOLD: begin
                    eng_d.ph  = PH_ACT;
                    eng_d.cnt = CW'(T_RAS - T_CHR - 1);
                end
                PH_ACT: begin
                    eng_d.ph  = PH_PRE;
                    eng_d.cnt = CW'(T_RP - 1);
                end
                default: begin
                    eng_d.ph  = PH_IDLE;
                    eng_d.cnt = '0;
                end
            endcase
        end
        eng_d.ras_n = !(eng_d.ph == PH_HOLD || eng_d.ph == PH_ACT);
        eng_d.cas_n = !(eng_d.ph == PH_CSR || eng_d.ph == PH_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{ph: PH_IDLE, cnt: '0, ras_n: 1'b1, cas_n: 1'b1, ror: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign ras_n_o    = eng_q.ras_n;
    assign cas_n_o    = eng_q.cas_n;
    assign busy_o     = (eng_q.ph != PH_IDLE);
    assign done_o     = (eng_q.ph == PH_PRE) && last;
    assign ras_only_o = eng_q.ror;
endmodule

// File: rtl/dref_debt.sv
module dref_debt #(
    parameter int INTERVAL_CYC = 3900,
    parameter int DEBT_MAX     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic take_i,
    output logic owed_o
);
    localparam int TW = $clog2(INTERVAL_CYC);
    localparam int DW = $clog2(DEBT_MAX + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [DW-1:0] debt;
    } debt_s;

    debt_s dbt_d, dbt_q;
    logic  tick, inc, dec;

    always_comb begin
        dbt_d = dbt_q;
        tick  = run_i && (dbt_q.tmr == TW'(INTERVAL_CYC - 1));
        inc   = tick && (dbt_q.debt < DW'(DEBT_MAX));
        dec   = take_i && (dbt_q.debt != '0);
        if (!run_i || tick) dbt_d.tmr = '0;
        else                dbt_d.tmr = dbt_q.tmr + TW'(1);
        dbt_d.debt = dbt_q.debt + DW'(inc) - DW'(dec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbt_q <= '0;
        else        dbt_q <= dbt_d;
    end

    assign owed_o = (dbt_q.debt != '0);
endmodule

// File: rtl/dref_row_ctr.sv
module dref_row_ctr #(
    parameter int ROW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    output logic [ROW_BITS-1:0] row_o
);
    logic [ROW_BITS-1:0] row_d, row_q;

    always_comb begin
        row_d = step_i ? row_q + ROW_BITS'(1) : row_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row_o = row_q;
endmodule

// File: rtl/dref_refresh_seq.sv
module dref_refresh_seq
    import dref_pkg::*;
#(
    parameter int PAUSE_CYC    = 25000,
    parameter int INIT_CYCLES  = 8,
    parameter int INTERVAL_CYC = 3900,
    parameter int DEBT_MAX     = 8,
    parameter int ROW_BITS     = 12,
    parameter int T_CSR        = 3,
    parameter int T_CHR        = 3,
    parameter int T_RAS        = 13,
    parameter int T_RP         = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grant_i,
    input  logic                ras_only_i,
    output logic                req_o,
    output logic                busy_o,
    output logic                init_done_o,
    output logic                ras_n_o,
    output logic                cas_n_o,
    output logic                we_n_o,
    output logic [ROW_BITS-1:0] addr_o
);
    localparam int PW = $clog2(PAUSE_CYC);
    localparam int IW = $clog2(INIT_CYCLES);

    typedef struct packed {
        seq_e          st;
        logic [PW-1:0] pcnt;
        logic [IW-1:0] icnt;
    } seq_s;

    seq_s seq_d, seq_q;
    logic eng_start, eng_busy, eng_done, eng_ror, owed, take;

    always_comb begin
        seq_d     = seq_q;
        eng_start = 1'b0;
        take      = 1'b0;
        case (seq_q.st)
            ST_PAUSE: begin
                if (seq_q.pcnt == PW'(PAUSE_CYC - 1)) seq_d.st = ST_INIT;
                else seq_d.pcnt = seq_q.pcnt + PW'(1);
            end
            ST_INIT: begin
                eng_start = !eng_busy;
                if (eng_done) begin
                    if (seq_q.icnt == IW'(INIT_CYCLES - 1)) seq_d.st = ST_RUN;
                    else seq_d.icnt = seq_q.icnt + IW'(1);
                end
            end
            default: begin
                eng_start = owed && grant_i && !eng_busy;
                take      = eng_start;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_PAUSE, pcnt: '0, icnt: '0};
        else        seq_q <= seq_d;
    end

    dref_strobe_engine #(
        .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (eng_start),
        .ras_only_i(ras_only_i),
        .ras_n_o   (ras_n_o),
        .cas_n_o   (cas_n_o),
        .busy_o    (eng_busy),
        .done_o    (eng_done),
        .ras_only_o(eng_ror)
    );

    dref_debt #(
        .INTERVAL_CYC(INTERVAL_CYC), .DEBT_MAX(DEBT_MAX)
    ) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (seq_q.st == ST_RUN),
        .take_i(take),
        .owed_o(owed)
    );

    dref_row_ctr #(.ROW_BITS(ROW_BITS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(eng_done && eng_ror),
        .row_o (addr_o)
    );

    assign req_o       = (seq_q.st == ST_RUN) && owed;
    assign init_done_o = (seq_q.st == ST_RUN);
    assign busy_o      = eng_busy;
    assign we_n_o      = 1'b1;
endmodule

// File: rtl/dref_seq_checker.sv
module dref_seq_checker #(
    parameter int T_RAS    = 13,
    parameter int T_RP     = 8,
    parameter int ROW_BITS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_o,
    input logic                busy_o,
    input logic                init_done_o,
    input logic                ras_n_o,
    input logic                cas_n_o,
    input logic [ROW_BITS-1:0] addr_o
);
    logic [15:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= ras_n_o ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
            hi_cnt <= !ras_n_o ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1);
        end
    end

    // R7: row strobe low width and precharge width
    assert_ras_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (lo_cnt >= 16'(T_RAS)));
    assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (hi_cnt >= 16'(T_RP)));
    // R7: column strobe already low before a column-first row fall
    assert_cas_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));
    // R8: column strobe never falls while the row strobe is held low
    assert_no_cas_under_ras_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && $past(!ras_n_o)) |-> !$fell(cas_n_o));
    // R9: row address steady while latched
    assert_addr_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && $past(!ras_n_o)) |-> $stable(addr_o));
    // R4: no request before initialization completes
    assert_req_after_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> init_done_o);
    // R3: init-done never drops
    assert_init_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done_o) |-> init_done_o);
    // R11: any strobe activity is covered by busy
    assert_busy_covers_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o || !cas_n_o) |-> busy_o);
endmodule

bind dref_refresh_seq dref_seq_checker #(
    .T_RAS(T_RAS), .T_RP(T_RP), .ROW_BITS(ROW_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_o      (req_o),
    .busy_o     (busy_o),
    .init_done_o(init_done_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .addr_o     (addr_o)
);

// File: tb/tb_dref_refresh_seq.sv
module tb_dref_refresh_seq;
    localparam int PAUSE = 200;
    localparam int NINIT = 8;
    localparam int IVL   = 1000;
    localparam int DMAX  = 8;
    localparam int RB    = 3;
    localparam int TCSR  = 3;
    localparam int TCHR  = 3;
    localparam int TRAS  = 13;
    localparam int TRP   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant_i = 1'b0;
    logic ras_only_i = 1'b0;
    logic req_o, busy_o, init_done_o, ras_n_o, cas_n_o, we_n_o;
    logic [RB-1:0] addr_o;

    always #2 clk = ~clk;

    dref_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INIT_CYCLES(NINIT), .INTERVAL_CYC(IVL),
        .DEBT_MAX(DMAX), .ROW_BITS(RB), .T_CSR(TCSR), .T_CHR(TCHR),
        .T_RAS(TRAS), .T_RP(TRP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .ras_only_i(ras_only_i),
        .req_o(req_o), .busy_o(busy_o), .init_done_o(init_done_o),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o)
    );

    typedef struct {bit cbr; int addr;} exp_t;
    exp_t exp_q[$];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_falls = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic expect_cycle(input bit cbr, input int addr);
        exp_t e;
        e.cbr = cbr;
        e.addr = addr;
        exp_q.push_back(e);
    endtask

    // monitor: measures every refresh cycle and compares with the queue
    bit prev_ras = 1'b1;
    int cas_lo_run = 0, ras_lo_run = 0, hold_run = 0;
    bit fall_cbr = 1'b0;
    int fall_lead = 0, fall_addr = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_ras && !ras_n_o) begin
                fall_cbr  = !cas_n_o;
                fall_lead = cas_lo_run;
                fall_addr = int'(addr_o);
                hold_run  = 0;
                n_falls++;
                check(busy_o == 1'b1, "R11 busy at row fall", busy_o, 1);
                check(we_n_o == 1'b1, "R10 write enable high", we_n_o, 1);
            end
            if (!prev_ras && ras_n_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R6 unexpected refresh cycle", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(fall_cbr == e.cbr, "R7/R8 cycle kind", fall_cbr, e.cbr);
                    check(ras_lo_run == TRAS, "R7 row strobe width", ras_lo_run, TRAS);
                    if (e.cbr) begin
                        check(fall_lead == TCSR, "R7 column lead", fall_lead, TCSR);
                        check(hold_run == TCHR, "R7 column hold", hold_run, TCHR);
                    end else begin
                        check(hold_run == 0, "R8 column stays high", hold_run, 0);
                        check(fall_addr == e.addr, "R9 row address", fall_addr, e.addr);
                    end
                end
            end
            cas_lo_run = cas_n_o ? 0 : cas_lo_run + 1;
            ras_lo_run = ras_n_o ? 0 : ras_lo_run + 1;
            if (!ras_n_o && !cas_n_o) hold_run++;
            prev_ras = ras_n_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int k;
        int t_tick;
        int f0;
        bit quiet;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check({req_o, busy_o, init_done_o} == 3'b000, "R1 flags in reset", {req_o, busy_o, init_done_o}, 0);
        check({ras_n_o, cas_n_o, we_n_o} == 3'b111, "R1 strobes in reset", {ras_n_o, cas_n_o, we_n_o}, 7);
        for (int i = 0; i < NINIT; i++) expect_cycle(1'b1, 0);
        rst_n = 1'b1;

        // R2 pause before any activity
        k = 0;
        while (ras_n_o && cas_n_o) begin
            @(negedge clk);
            k++;
        end
        check(k >= PAUSE && k <= PAUSE + 2, "R2 pause length", k, PAUSE + 1);
        check(init_done_o == 1'b0, "R2 init-done low after pause", init_done_o, 0);

        // R3 eight grantless cycles then init-done
        while (!init_done_o) @(negedge clk);
        check(n_falls == NINIT, "R3 init cycle count", n_falls, NINIT);
        check(exp_q.size() == 0, "R3 init cycles served", exp_q.size(), 0);

        // R4 first interval tick raises request
        k = 0;
        quiet = 1'b1;
        while (!req_o) begin
            @(negedge clk);
            k++;
            if (!ras_n_o || !cas_n_o) quiet = 1'b0;
        end
        t_tick = cyc;
        check(k >= IVL - 1 && k <= IVL + 1, "R4 interval to request", k, IVL);
        check(quiet, "R4 no activity while waiting", quiet, 1);
        expect_cycle(1'b1, 0);
        grant_i = 1'b1;
        while (req_o) @(negedge clk);
        grant_i = 1'b0;
        while (busy_o) @(negedge clk);
        check({ras_n_o, cas_n_o, busy_o} == 3'b110, "R11 idle after cycle", {ras_n_o, cas_n_o, busy_o}, 6);
        check(exp_q.size() == 0, "R4 granted cycle served", exp_q.size(), 0);

        // R5 saturation: withhold grants for many intervals
        for (int i = 0; i < DMAX; i++) expect_cycle(1'b1, 0);
        while (cyc < t_tick + 11 * IVL + IVL / 2) @(negedge clk);
        check(req_o == 1'b1, "R5 request pending", req_o, 1);
        f0 = n_falls;
        grant_i = 1'b1;
        while (req_o) @(negedge clk);
        grant_i = 1'b0;
        while (busy_o) @(negedge clk);
        check(n_falls - f0 == DMAX, "R5 saturated debt served", n_falls - f0, DMAX);
        check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

        // R6 grant without request is ignored
        quiet = 1'b1;
        grant_i = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!ras_n_o || !cas_n_o || busy_o || req_o) quiet = 1'b0;
        end
        grant_i = 1'b0;
        check(quiet, "R6 stray grant ignored", quiet, 1);
        check(n_falls == f0 + DMAX, "R6 no extra cycle", n_falls, f0 + DMAX);

        // R8/R9 RAS-only cycles with row counter wrap
        ras_only_i = 1'b1;
        for (int i = 0; i < (1 << RB) + 2; i++) expect_cycle(1'b0, i % (1 << RB));
        grant_i = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        grant_i = 1'b0;
        while (busy_o) @(negedge clk);
        check(addr_o == RB'(2), "R9 counter after wrap", addr_o, 2);
        check(init_done_o == 1'b1, "R3 init-done held", init_done_o, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule